// File: doc/BRIEF.md
# Audio Transmit Sample FIFO

This block is a small per-stream playback buffer placed between a DMA engine and the slot formatter of a serial audio link. On the DMA side it holds a request line high while the stream is enabled and free space remains, and it takes one sample word on each write strobe. On the link side, each slot data request receives a sample word and a valid flag one cycle later.

After the stream is enabled, no valid sample is released until the buffer has been completely filled once. This builds up as much buffering as possible before playback starts. Once priming is over, a request that finds the buffer empty is an underrun. The block then returns an invalid, all-zero sample and sets a sticky error flag. Software clears that flag with a write-one-to-clear pulse. An interrupt line follows the flag while error-halt is enabled. To recover, software drops the stream enable and raises it again. This empties the buffer and restarts the priming phase.

Top module: `atx_sample_fifo`

## Requirements
- R1: `dma_req` is high in the same cycle exactly when `stream_en` is 1 and fewer than DEPTH words are stored.
- R2: A `wr_stb` pulse stores `wr_data` only while `stream_en` is 1 and the buffer is not full. Otherwise the pulse is ignored and the stored contents do not change.
- R3: After priming, a `link_req` pulse in cycle t makes `slot_valid` 1 and `slot_data` the oldest stored word from cycle t+1, and removes that word. Words leave in the order they were written.
- R4: From enable until the buffer has been full once, every `link_req` is answered with `slot_valid` 0 and `slot_data` 0. Such a request removes no word and does not set `udr_flag`. A request in the same cycle the buffer first reads full is served normally.
- R5: After priming, a `link_req` that finds the buffer empty is answered with `slot_valid` 0 and `slot_data` 0, and `udr_flag` is 1 from the next cycle.
- R6: `udr_flag` stays set until a `udr_clr` pulse clears it. A new underrun in the same cycle as `udr_clr` leaves the flag set.
- R7: `irq` equals `udr_flag` AND `halt_en`.
- R8: While `stream_en` is 0, `dma_req` is 0 in that cycle, the next clock edge empties the buffer and clears the priming state, and `udr_flag` is kept. A `link_req` while disabled gets `slot_valid` 0 and `slot_data` 0 without error.
- R9: The capacity equals parameter DEPTH, from 1 upward. The buffer reads full after DEPTH accepted writes.
- R10: After priming, a write and a link request in the same cycle both take effect. The oldest word is returned and the new word is kept.
- R11: `slot_valid` and `slot_data` change only on a `link_req` cycle and hold between requests. All outputs reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stream_en | input | 1 | Stream enable; 0 flushes and re-arms priming |
| halt_en | input | 1 | Error-halt enable, gates `irq` |
| wr_stb | input | 1 | DMA write strobe |
| wr_data | input | W | DMA sample word |
| dma_req | output | 1 | Request for more samples |
| link_req | input | 1 | Link-side slot data request |
| slot_valid | output | 1 | Valid flag of the returned sample |
| slot_data | output | W | Returned sample, zero when not valid |
| udr_clr | input | 1 | Write-one-to-clear pulse for `udr_flag` |
| udr_flag | output | 1 | Sticky underrun error |
| irq | output | 1 | Underrun interrupt |

## Verification
Two pairs of functions can fall on the same clock edge. The first pair is a DMA write and a link request. The second is a fresh underrun and the software clear of the flag. The bench provokes the first with a single cycle that drives `wr_stb` and `link_req` together while one word is stored. It judges the result from the returned word and from the next request, which must return the new word. It provokes the second by pulsing `udr_clr` in the cycle of a request on an empty, primed buffer, and expects `udr_flag` to remain 1.

// File: rtl/atx_pkg.sv
// Shared types for the audio transmit sample FIFO.
package atx_pkg;
    // Kind of answer given to one link-side request.
    typedef enum logic [1:0] {
        RSP_IDLE     = 2'd0,
        RSP_PREFILL  = 2'd1,
        RSP_DATA     = 2'd2,
        RSP_UNDERRUN = 2'd3
    } rsp_kind_e;
endpackage

// File: rtl/atx_store.sv
// Ring buffer of DEPTH words. Flush has priority over push and pop.
// Assumes the caller never pushes when full nor pops when empty.
module atx_store #(
    parameter int W     = 16,
    parameter int DEPTH = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         full,
    output logic         empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] fill;

    function automatic logic [PW-1:0] step_ptr(input logic [PW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    // Pointer and fill bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (push) wr_ptr <= step_ptr(wr_ptr);
            if (pop)  rd_ptr <= step_ptr(rd_ptr);
            case ({push, pop})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

    // Sample storage, written without reset.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wdata;
    end

    assign head  = mem[rd_ptr];
    assign full  = (fill == CW'(DEPTH));
    assign empty = (fill == '0);

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CW'(DEPTH));
    assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);
    assert_push_grows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        push && !pop && !flush |=> !empty);
endmodule

// File: rtl/atx_ctrl.sv
// Link-side answer logic. It tracks priming, decides whether each
// request is served, withheld or an underrun, and keeps the sticky
// underrun flag. Assumes the store reports full and empty from
// registered state.
module atx_ctrl
    import atx_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         stream_en,
    input  logic         halt_en,
    input  logic         link_req,
    input  logic         udr_clr,
    input  logic         full,
    input  logic         empty,
    input  logic [W-1:0] head,
    output logic         pop,
    output logic         slot_valid,
    output logic [W-1:0] slot_data,
    output logic         udr_flag,
    output logic         irq
);
    logic      primed_q;
    rsp_kind_e kind;

    // Classify the current request.
    always_comb begin
        if (!link_req)                          kind = RSP_IDLE;
        else if (!stream_en || !(primed_q || full)) kind = RSP_PREFILL;
        else if (empty)                         kind = RSP_UNDERRUN;
        else                                    kind = RSP_DATA;
    end

    assign pop = (kind == RSP_DATA);

    // Priming: set once full while enabled, cleared by disable.
    always_ff @(posedge clk) begin
        if (!rst_n) primed_q <= 1'b0;
        else        primed_q <= stream_en && (primed_q || full);
    end

    // Registered slot answer, updated only on a request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_valid <= 1'b0;
            slot_data  <= '0;
        end else if (link_req) begin
            slot_valid <= (kind == RSP_DATA);
            slot_data  <= (kind == RSP_DATA) ? head : '0;
        end
    end

    // Sticky underrun flag; a new underrun beats the clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                    udr_flag <= 1'b0;
        else if (kind == RSP_UNDERRUN) udr_flag <= 1'b1;
        else if (udr_clr)              udr_flag <= 1'b0;
    end

    assign irq = udr_flag & halt_en;

    assert_withheld_R4: assert property (@(posedge clk) disable iff (!rst_n)
        link_req && !primed_q && !full |=> !slot_valid && slot_data == '0);
    assert_underrun_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        link_req && stream_en && primed_q && empty |=> udr_flag && !slot_valid);
    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        udr_flag && !udr_clr |=> udr_flag);
    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !link_req |=> $stable(slot_valid) && $stable(slot_data));
endmodule

// File: rtl/atx_sample_fifo.sv
// Top of the audio transmit sample FIFO: gates DMA writes with the
// stream enable and free space, and joins the store with the
// link-side answer logic. Assumes all inputs are synchronous to clk.
module atx_sample_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         stream_en,
    input  logic         halt_en,
    input  logic         wr_stb,
    input  logic [W-1:0] wr_data,
    output logic         dma_req,
    input  logic         link_req,
    output logic         slot_valid,
    output logic [W-1:0] slot_data,
    input  logic         udr_clr,
    output logic         udr_flag,
    output logic         irq
);
    logic         full, empty, pop, push;
    logic [W-1:0] head;

    assign push    = wr_stb && stream_en && !full;
    assign dma_req = stream_en && !full;

    atx_store #(.W(W), .DEPTH(DEPTH)) i_store (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (!stream_en),
        .push  (push),
        .wdata (wr_data),
        .pop   (pop),
        .head  (head),
        .full  (full),
        .empty (empty)
    );

    atx_ctrl #(.W(W)) i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .stream_en  (stream_en),
        .halt_en    (halt_en),
        .link_req   (link_req),
        .udr_clr    (udr_clr),
        .full       (full),
        .empty      (empty),
        .head       (head),
        .pop        (pop),
        .slot_valid (slot_valid),
        .slot_data  (slot_data),
        .udr_flag   (udr_flag),
        .irq        (irq)
    );

    assert_req_off_when_full_R1: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !dma_req);
    assert_req_off_when_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !stream_en |-> !dma_req);
endmodule

// File: tb/test_atx_sample_fifo.sv
// Scoreboard bench: the step task predicts each link answer into a
// queue, and a monitor pops and compares when the answer appears.
module test_atx_sample_fifo;
    localparam int W = 16;
    localparam int DEPTH = 3;
    localparam time CLK_PERIOD = 10ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stream_en = 1'b0, halt_en = 1'b0, wr_stb = 1'b0, link_req = 1'b0, udr_clr = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic dma_req, slot_valid, udr_flag, irq;
    logic [W-1:0] slot_data;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 0;
    string phase = "reset";

    logic [W-1:0] m_q[$];
    bit m_primed = 0;
    bit m_udr = 0;
    bit exp_v[$];
    logic [W-1:0] exp_d[$];
    logic req_d = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    atx_sample_fifo #(.W(W), .DEPTH(DEPTH)) i_atx_sample_fifo (
        .clk(clk), .rst_n(rst_n), .stream_en(stream_en), .halt_en(halt_en),
        .wr_stb(wr_stb), .wr_data(wr_data), .dma_req(dma_req),
        .link_req(link_req), .slot_valid(slot_valid), .slot_data(slot_data),
        .udr_clr(udr_clr), .udr_flag(udr_flag), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Remember whether a request was taken at the edge.
    always @(posedge clk) req_d <= link_req;

    // Monitor: compare each answer one cycle after its request.
    always @(negedge clk) begin
        if (req_d) begin
            if (exp_v.size() == 0) begin
                chk({phase, " scoreboard empty"}, 1, 0);
            end else begin
                chk({phase, " slot_valid"}, 32'(slot_valid), 32'(exp_v.pop_front()));
                chk({phase, " slot_data"}, 32'(slot_data), 32'(exp_d.pop_front()));
            end
        end
    end

    // One cycle of stimulus, starting and ending at a falling edge.
    task automatic step(input bit wr, input logic [W-1:0] d, input bit req, input bit clr);
        bit full_pre, pe, set_u, popm;
        wr_stb = wr; wr_data = d; link_req = req; udr_clr = clr;
        #1;
        chk({phase, " R1 dma_req"}, 32'(dma_req), 32'(stream_en && m_q.size() < DEPTH));
        full_pre = (m_q.size() == DEPTH);
        pe = m_primed || full_pre;
        set_u = 0; popm = 0;
        if (req) begin
            if (!stream_en || !pe) begin
                exp_v.push_back(0); exp_d.push_back('0);
            end else if (m_q.size() > 0) begin
                exp_v.push_back(1); exp_d.push_back(m_q[0]); popm = 1;
            end else begin
                exp_v.push_back(0); exp_d.push_back('0); set_u = 1;
            end
        end
        @(posedge clk);
        if (popm) void'(m_q.pop_front());
        if (wr && stream_en && !full_pre) m_q.push_back(d);
        if (!stream_en) m_q.delete();
        m_primed = stream_en && pe;
        m_udr = set_u ? 1'b1 : (clr ? 1'b0 : m_udr);
        @(negedge clk);
        wr_stb = 0; link_req = 0; udr_clr = 0;
        chk({phase, " R6 udr_flag"}, 32'(udr_flag), 32'(m_udr));
        chk({phase, " R7 irq"}, 32'(irq), 32'(m_udr && halt_en));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11: reset values.
        phase = "R11 reset";
        chk("R11 reset slot_valid", 32'(slot_valid), 0);
        chk("R11 reset slot_data", 32'(slot_data), 0);
        chk("R11 reset udr_flag", 32'(udr_flag), 0);
        chk("R11 reset dma_req", 32'(dma_req), 0);

        // R8: writes and requests while disabled are ignored.
        phase = "R8 disabled";
        step(1, 16'h0BAD, 1, 0);
        stream_en = 1'b1;
        phase = "R2 empty after disabled write";
        step(0, '0, 0, 0);

        // R4: priming withholds data, no error, no removal.
        phase = "R4 prefill";
        step(1, 16'hA001, 0, 0);
        step(0, '0, 1, 0);
        step(1, 16'hA002, 1, 0);
        // R9: third write fills the buffer; R1 request drops.
        phase = "R9 fill";
        step(1, 16'hA003, 0, 0);
        // R2: write while full ignored.
        phase = "R2 full write";
        step(1, 16'hDEAD, 0, 0);

        // R3: ordered delivery.
        phase = "R3 order";
        step(0, '0, 1, 0);
        step(0, '0, 0, 0);
        chk("R11 hold slot_data", 32'(slot_data), 32'h0000A001);
        step(0, '0, 1, 0);
        step(0, '0, 1, 0);

        // R5: underrun on empty, primed buffer; R7 interrupt.
        phase = "R5 underrun";
        halt_en = 1'b1;
        step(0, '0, 1, 0);
        halt_en = 1'b0;
        phase = "R7 irq gated";
        step(0, '0, 0, 0);
        phase = "R6 clear";
        step(0, '0, 0, 1);
        // R6: new underrun in same cycle as clear wins.
        phase = "R6 set beats clear";
        step(0, '0, 1, 1);
        step(0, '0, 0, 1);

        // R10: simultaneous write and request.
        phase = "R10 push+pop";
        step(1, 16'hB001, 0, 0);
        step(1, 16'hB002, 1, 0);
        step(0, '0, 1, 0);

        // R8: disable flushes and re-arms priming; flag kept.
        phase = "R8 disable";
        step(1, 16'hC001, 0, 0);
        step(0, '0, 1, 0);
        step(1, 16'hC002, 0, 0);
        stream_en = 1'b0;
        step(0, '0, 0, 0);
        stream_en = 1'b1;
        phase = "R8 re-enable prefill";
        step(1, 16'hD001, 1, 0);
        step(0, '0, 1, 0);
        step(1, 16'hD002, 0, 0);
        // R4: request in the cycle the buffer first reads full is served.
        step(1, 16'hD003, 0, 0);
        phase = "R4 served at full";
        step(0, '0, 1, 0);
        step(0, '0, 1, 0);
        step(0, '0, 1, 0);
        phase = "R5 second underrun";
        step(0, '0, 1, 0);
        step(0, '0, 0, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule